// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit

This unit carries out the 16-bit operations of a small processor that work on whole register pairs: the three general pairs (BC, DE, HL) and the stack pointer. A sequencer presents the current pair values, an 8-bit immediate byte, the carry flag and an operation code together with a one-cycle start pulse. The unit captures them, waits the number of clock states that operation takes, and then presents the updated pairs and flags together with a one-cycle done strobe.

The operation set covers pair increment and decrement, the double add into HL, HL minus BC, the sign-keeping right shift of HL, the left rotate of DE through carry, and forming DE from HL or the stack pointer plus an unsigned byte. Each operation reports a write mask telling the sequencer which flags it may commit. Pairs that the operation does not target come back equal to their captured values.

Top module: `rp_arith_unit`

## Requirements
- R1: Operation code 0 increments and code 1 decrements the pair chosen by `pair_sel` (0 = BC, 1 = DE, 2 = HL, 3 = SP), wrapping modulo 2^16; the flag write mask is 0 and every other pair is returned unchanged.
- R2: Operation code 2 sets HL to HL plus the pair chosen by `pair_sel` modulo 2^16, reports carry as the carry out of bit 15, and writes only the carry flag (mask 4'b0010).
- R3: Operation code 3 sets HL to HL minus BC modulo 2^16; carry is 1 when BC is greater than HL, zero is 1 when the result is 0, sign is result bit 15, half-carry is 1 when BC bits 11:0 exceed HL bits 11:0; all four flags are written (mask 4'b1111).
- R4: Operation code 4 shifts HL right by one, keeps the old bit 15 in bit 15, moves old bit 0 into carry and writes only carry (mask 4'b0010).
- R5: Operation code 5 shifts DE left by one, loads the incoming carry into bit 0, moves old bit 15 into carry and writes only carry (mask 4'b0010).
- R6: Operation code 6 sets DE to HL plus the zero-extended immediate and code 7 sets DE to SP plus the zero-extended immediate, both modulo 2^16, with a flag write mask of 0.
- R7: `flags` and `flags_wr` use bit 0 = zero, bit 1 = carry, bit 2 = sign, bit 3 = half-carry; a flag outside the write mask reads 0, except carry, which reads back the captured carry input.
- R8: `done` is high after the Nth rising edge counting the edge that samples an accepted `start` as the first, with N = 6 for codes 0 and 1, 7 for code 4 and 10 for codes 2, 3, 5, 6 and 7; `busy` is high from the accepting edge until `done` rises.
- R9: `done` lasts one cycle, and the result outputs hold their value until the next `done`, whatever the inputs do in between.
- R10: A `start` pulse while `busy` is high is ignored: it neither changes the pending result nor its timing, and produces no extra `done`.
- R11: After reset `busy` and `done` are low and all pair, flag and mask outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 3 | Operation code |
| pair_sel | input | 2 | Pair selector for increment, decrement and double add |
| bc_in | input | 16 | Current BC pair |
| de_in | input | 16 | Current DE pair |
| hl_in | input | 16 | Current HL pair |
| sp_in | input | 16 | Current stack pointer |
| imm | input | 8 | Immediate byte |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle result strobe |
| bc_out | output | 16 | Resulting BC pair |
| de_out | output | 16 | Resulting DE pair |
| hl_out | output | 16 | Resulting HL pair |
| sp_out | output | 16 | Resulting stack pointer |
| flags | output | 4 | Resulting flag values |
| flags_wr | output | 4 | Flags the operation writes |

## Verification
The hardest state to reach from the ports is a second start arriving in the middle of a running operation, because the sequencer that normally drives the unit never does that. The bench re-pulses start with a different operation code three cycles into selected runs and then checks that the result, its latency and the count of done strobes all match the first request alone. Flag corners such as an exactly zero difference, a borrow out of bit 11 only, and wrap of the byte-added forms are forced by dedicated operand patterns mixed into the pseudo-random sweep over every operation and pair selector.

// File: rtl/rp_arith_pkg.sv
package rp_arith_pkg;

    typedef enum logic [2:0] {
        OP_INC   = 3'd0,
        OP_DEC   = 3'd1,
        OP_DAD   = 3'd2,
        OP_HLSUB = 3'd3,
        OP_HLSHR = 3'd4,
        OP_DEROL = 3'd5,
        OP_DEHL  = 3'd6,
        OP_DESP  = 3'd7
    } rp_op_e;

    typedef enum logic [1:0] {
        PR_BC = 2'd0,
        PR_DE = 2'd1,
        PR_HL = 2'd2,
        PR_SP = 2'd3
    } rp_sel_e;

    // bit 0 zero, bit 1 carry, bit 2 sign, bit 3 half-carry
    typedef struct packed {
        logic h;
        logic s;
        logic c;
        logic z;
    } rp_flags_t;

    localparam int LAT_STEP  = 6;
    localparam int LAT_SHIFT = 7;
    localparam int LAT_LONG  = 10;
    localparam int CNT_W     = $clog2(LAT_LONG + 1);

    function automatic logic [CNT_W-1:0] op_latency(rp_op_e op);
        case (op)
            OP_INC, OP_DEC: op_latency = CNT_W'(LAT_STEP);
            OP_HLSHR:       op_latency = CNT_W'(LAT_SHIFT);
            default:        op_latency = CNT_W'(LAT_LONG);
        endcase
    endfunction

endpackage

// File: rtl/rp_op_unit.sv
module rp_op_unit
    import rp_arith_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  rp_op_e           op,
    input  rp_sel_e          sel,
    input  logic [W-1:0]     bc,
    input  logic [W-1:0]     de,
    input  logic [W-1:0]     hl,
    input  logic [W-1:0]     sp,
    input  logic [IMM_W-1:0] imm,
    input  logic             cin,
    output logic [W-1:0]     nbc,
    output logic [W-1:0]     nde,
    output logic [W-1:0]     nhl,
    output logic [W-1:0]     nsp,
    output rp_flags_t        fl,
    output rp_flags_t        wr
);

    localparam int LOW_W = W - 4;

    logic [W-1:0]     pv;
    logic [W-1:0]     step;
    logic [W:0]       dad_sum;
    logic [W:0]       diff;
    logic [LOW_W:0]   low_diff;
    logic [W-1:0]     ext;

    always_comb begin
        case (sel)
            PR_BC:   pv = bc;
            PR_DE:   pv = de;
            PR_HL:   pv = hl;
            default: pv = sp;
        endcase
    end

    assign step     = (op == OP_INC) ? pv + W'(1) : pv - W'(1);
    assign dad_sum  = {1'b0, hl} + {1'b0, pv};
    assign diff     = {1'b0, hl} - {1'b0, bc};
    assign low_diff = {1'b0, hl[LOW_W-1:0]} - {1'b0, bc[LOW_W-1:0]};
    assign ext      = {{(W-IMM_W){1'b0}}, imm};

    always_comb begin
        nbc  = bc;
        nde  = de;
        nhl  = hl;
        nsp  = sp;
        fl   = '0;
        fl.c = cin;
        wr   = '0;
        case (op)
            OP_INC, OP_DEC: begin
                case (sel)
                    PR_BC:   nbc = step;
                    PR_DE:   nde = step;
                    PR_HL:   nhl = step;
                    default: nsp = step;
                endcase
            end
            OP_DAD: begin
                nhl  = dad_sum[W-1:0];
                fl.c = dad_sum[W];
                wr.c = 1'b1;
            end
            OP_HLSUB: begin
                nhl  = diff[W-1:0];
                fl.c = diff[W];
                fl.z = (diff[W-1:0] == '0);
                fl.s = diff[W-1];
                fl.h = low_diff[LOW_W];
                wr   = '1;
            end
            OP_HLSHR: begin
                nhl  = {hl[W-1], hl[W-1:1]};
                fl.c = hl[0];
                wr.c = 1'b1;
            end
            OP_DEROL: begin
                nde  = {de[W-2:0], cin};
                fl.c = de[W-1];
                wr.c = 1'b1;
            end
            OP_DEHL: nde = hl + ext;
            default: nde = sp + ext;
        endcase
    end

endmodule

// File: rtl/rp_seq.sv
module rp_seq
    import rp_arith_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] lat,
    output logic             accept,
    output logic             busy,
    output logic             fire
);

    logic [CNT_W-1:0] cnt;

    assign accept = start && !busy;
    assign fire   = busy && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= lat - CNT_W'(1);
        end else if (busy) begin
            if (fire) busy <= 1'b0;
            else      cnt  <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/rp_arith_unit.sv
module rp_arith_unit
    import rp_arith_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [1:0]       pair_sel,
    input  logic [W-1:0]     bc_in,
    input  logic [W-1:0]     de_in,
    input  logic [W-1:0]     hl_in,
    input  logic [W-1:0]     sp_in,
    input  logic [IMM_W-1:0] imm,
    input  logic             carry_in,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     bc_out,
    output logic [W-1:0]     de_out,
    output logic [W-1:0]     hl_out,
    output logic [W-1:0]     sp_out,
    output logic [3:0]       flags,
    output logic [3:0]       flags_wr
);

    rp_op_e           op_q;
    rp_sel_e          sel_q;
    logic [W-1:0]     bc_q, de_q, hl_q, sp_q;
    logic [IMM_W-1:0] imm_q;
    logic             cin_q;

    logic             accept, fire;
    logic [W-1:0]     nbc, nde, nhl, nsp;
    rp_flags_t        nfl, nwr;

    rp_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .lat    (op_latency(rp_op_e'(op))),
        .accept (accept),
        .busy   (busy),
        .fire   (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_INC;
            sel_q <= PR_BC;
            bc_q  <= '0;
            de_q  <= '0;
            hl_q  <= '0;
            sp_q  <= '0;
            imm_q <= '0;
            cin_q <= 1'b0;
        end else if (accept) begin
            op_q  <= rp_op_e'(op);
            sel_q <= rp_sel_e'(pair_sel);
            bc_q  <= bc_in;
            de_q  <= de_in;
            hl_q  <= hl_in;
            sp_q  <= sp_in;
            imm_q <= imm;
            cin_q <= carry_in;
        end
    end

    rp_op_unit #(.W(W), .IMM_W(IMM_W)) u_op (
        .op  (op_q),
        .sel (sel_q),
        .bc  (bc_q),
        .de  (de_q),
        .hl  (hl_q),
        .sp  (sp_q),
        .imm (imm_q),
        .cin (cin_q),
        .nbc (nbc),
        .nde (nde),
        .nhl (nhl),
        .nsp (nsp),
        .fl  (nfl),
        .wr  (nwr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            bc_out   <= '0;
            de_out   <= '0;
            hl_out   <= '0;
            sp_out   <= '0;
            flags    <= '0;
            flags_wr <= '0;
        end else begin
            done <= fire;
            if (fire) begin
                bc_out   <= nbc;
                de_out   <= nde;
                hl_out   <= nhl;
                sp_out   <= nsp;
                flags    <= nfl;
                flags_wr <= nwr;
            end
        end
    end

endmodule

// File: rtl/rp_arith_chk.sv
module rp_arith_chk
    import rp_arith_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input rp_op_e       op_q,
    input rp_sel_e      sel_q,
    input logic [W-1:0] de_q,
    input logic [W-1:0] de_out,
    input logic [W-1:0] hl_out,
    input logic [3:0]   flags_wr
);

    logic [7:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= 8'd1;
        else if (busy)           lat_cnt <= lat_cnt + 8'd1;
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == 8'(op_latency(op_q))));

    p_step_noflags_r1: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_INC || op_q == OP_DEC)) |-> (flags_wr == 4'b0000));

    p_step_keep_de_r1: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_INC || op_q == OP_DEC) && sel_q != PR_DE)
            |-> (de_out == de_q));

    p_shr_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_HLSHR) |-> (hl_out[W-1] == hl_out[W-2]));

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(op_q));

endmodule

bind rp_arith_unit rp_arith_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .op_q     (op_q),
    .sel_q    (sel_q),
    .de_q     (de_q),
    .de_out   (de_out),
    .hl_out   (hl_out),
    .flags_wr (flags_wr)
);

// File: tb/rp_arith_unit_bench.sv
`timescale 1ns/1ps
module rp_arith_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic [1:0]  pair_sel;
    logic [15:0] bc_in, de_in, hl_in, sp_in;
    logic [7:0]  imm;
    logic        carry_in;
    logic        busy, done;
    logic [15:0] bc_out, de_out, hl_out, sp_out;
    logic [3:0]  flags, flags_wr;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1F2E_3D4C;

    always #4 clk = ~clk;

    rp_arith_unit u_rp_arith_unit (
        .clk(clk), .rst(rst), .start(start), .op(op), .pair_sel(pair_sel),
        .bc_in(bc_in), .de_in(de_in), .hl_in(hl_in), .sp_in(sp_in),
        .imm(imm), .carry_in(carry_in), .busy(busy), .done(done),
        .bc_out(bc_out), .de_out(de_out), .hl_out(hl_out), .sp_out(sp_out),
        .flags(flags), .flags_wr(flags_wr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = {seed[30:0], seed[31] ^ seed[21] ^ seed[1] ^ seed[0]};
        seed = {seed[30:0], seed[31] ^ seed[21] ^ seed[1] ^ seed[0]} ^ (seed << 7);
        return seed;
    endfunction

    function automatic string req_of(input int o);
        case (o)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_op(input int o, input int s,
                          input logic [15:0] bc, de, hl, sp,
                          input logic [7:0] im, input logic ci, input bit poke);
        logic [15:0] ebc, ede, ehl, esp, pv;
        logic [16:0] w;
        logic [3:0]  ef, em;
        int          lat, k;
        string       rq;
        ebc = bc; ede = de; ehl = hl; esp = sp;
        ef = {2'b00, ci, 1'b0};
        em = 4'b0000;
        case (s)
            0: pv = bc;
            1: pv = de;
            2: pv = hl;
            default: pv = sp;
        endcase
        case (o)
            0, 1: begin
                pv = (o == 0) ? pv + 16'd1 : pv - 16'd1;
                case (s)
                    0: ebc = pv;
                    1: ede = pv;
                    2: ehl = pv;
                    default: esp = pv;
                endcase
            end
            2: begin
                w = 17'(hl) + 17'(pv);
                ehl = w[15:0]; ef[1] = w[16]; em = 4'b0010;
            end
            3: begin
                ehl = hl - bc;
                ef[0] = (hl == bc);
                ef[1] = (bc > hl);
                ef[2] = ehl[15];
                ef[3] = (bc[11:0] > hl[11:0]);
                em = 4'b1111;
            end
            4: begin
                ehl = 16'($signed(hl) >>> 1); ef[1] = hl[0]; em = 4'b0010;
            end
            5: begin
                ede = {de[14:0], ci}; ef[1] = de[15]; em = 4'b0010;
            end
            6: ede = hl + {8'd0, im};
            default: ede = sp + {8'd0, im};
        endcase
        lat = (o <= 1) ? 6 : (o == 4) ? 7 : 10;
        rq = req_of(o);

        @(negedge clk);
        op = 3'(o); pair_sel = 2'(s);
        bc_in = bc; de_in = de; hl_in = hl; sp_in = sp; imm = im; carry_in = ci;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (done !== 1'b1 && k < 20) begin
            if (poke && k == 3) begin
                start = 1'b1;              // R10: request while busy
                op = 3'(o) ^ 3'd5;
                hl_in = ~hl;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk("R8", $sformatf("latency op%0d", o), 32'(k), 32'(lat));
        chk(rq, "bc", 32'(bc_out), 32'(ebc));
        chk(rq, "de", 32'(de_out), 32'(ede));
        chk(rq, "hl", 32'(hl_out), 32'(ehl));
        chk(rq, "sp", 32'(sp_out), 32'(esp));
        chk("R7", $sformatf("flags op%0d", o), 32'(flags), 32'(ef));
        chk("R7", $sformatf("mask op%0d", o), 32'(flags_wr), 32'(em));
        if (poke) begin
            // R9 and R10: no second strobe, results held while inputs move
            for (int j = 0; j < 12; j++) begin
                bc_in = 16'(rnd()); hl_in = 16'(rnd());
                @(negedge clk);
                chk("R10", "extra done", 32'(done), 32'd0);
            end
            chk("R9", "held hl", 32'(hl_out), 32'(ehl));
            chk("R9", "held de", 32'(de_out), 32'(ede));
            chk("R9", "held flags", 32'(flags), 32'(ef));
        end else begin
            @(negedge clk);
            chk("R9", "done one cycle", 32'(done), 32'd0);
        end
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op = '0; pair_sel = '0;
        bc_in = '0; de_in = '0; hl_in = '0; sp_in = '0; imm = '0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11", "busy", 32'(busy), 32'd0);
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "pairs", 32'(bc_out | de_out | hl_out | sp_out), 32'd0);
        chk("R11", "flags", 32'({flags, flags_wr}), 32'd0);

        // directed corners
        run_op(3, 0, 16'h1234, 16'h0, 16'h1234, 16'h0, 8'h0, 1'b0, 0); // R3 zero
        run_op(3, 0, 16'h0F01, 16'h0, 16'h1000, 16'h0, 8'h0, 1'b0, 0); // R3 half borrow only
        run_op(3, 0, 16'h0001, 16'h0, 16'h0000, 16'h0, 8'h0, 1'b1, 0); // R3 full borrow
        run_op(4, 0, 16'h0, 16'h0, 16'h8001, 16'h0, 8'h0, 1'b0, 0);    // R4 negative
        run_op(5, 0, 16'h0, 16'h8000, 16'h0, 16'h0, 8'h0, 1'b1, 0);    // R5 carry in/out
        run_op(6, 0, 16'h0, 16'h0, 16'hFFF0, 16'h0, 8'hFF, 1'b1, 0);   // R6 wrap
        run_op(7, 0, 16'h0, 16'h0, 16'h0, 16'hFF80, 8'h80, 1'b0, 0);   // R6 wrap via SP
        run_op(0, 3, 16'h0, 16'h0, 16'h0, 16'hFFFF, 8'h0, 1'b1, 0);    // R1 wrap up
        run_op(1, 0, 16'h0000, 16'h0, 16'h0, 16'h0, 8'h0, 1'b0, 0);    // R1 wrap down
        run_op(2, 2, 16'h0, 16'h0, 16'h8000, 16'h0, 8'h0, 1'b0, 0);    // R2 HL+HL carry

        // sweep every operation and selector
        for (int o = 0; o < 8; o++) begin
            for (int s = 0; s < 4; s++) begin
                for (int p = 0; p < 18; p++) begin
                    logic [15:0] a, b, c, d;
                    a = 16'(rnd()); b = 16'(rnd()); c = 16'(rnd()); d = 16'(rnd());
                    if (p == 0) begin a = '0; b = '0; c = '0; d = '0; end
                    if (p == 1) begin a = '1; b = '1; c = '1; d = '1; end
                    if (p == 2) a = c;
                    run_op(o, s, a, b, c, d, 8'(rnd()), rnd() > 32'h7FFF_FFFF,
                           (p == 5));
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule